// File: doc/BRIEF.md
# Per-Core Private Countdown Timer

This block is a 32-bit down-counter with a small register interface. One copy sits beside each processor core. Software programs a reload value, an operating mode and an 8-bit clock divider. The block then counts down and raises a level interrupt each time the count expires. Two modes are available. In one-shot mode the timer stops at zero. In auto-reload mode it refills itself from the reload register and keeps counting.

The bus is a plain single-cycle word interface. A write takes effect at the clock edge where `busSel` and `busWr` are both high. Read data is combinational from the address while `busSel` is high and `busWr` is low. Four word registers sit in a 32-byte window: reload value (byte offset 0x0), live count (0x4), control (0x8) and event flag (0xC). Control bit 0 is run enable, bit 1 selects auto-reload, bit 2 unmasks the interrupt, and bits 15:8 hold the divider value P. All other control bits are reserved.

Several writes of zero have defined behaviour. With P equal to zero, such a write either halts the counter quietly or substitutes the reload value. This lets software stop or re-arm the timer without producing a spurious event.

Top module: `core_private_timer`

## Requirements
- R1: After reset, the reload, count, control and event-flag registers all read zero, the counter is halted and `irq` is low.
- R2: The only registers are at word offsets 0x0, 0x4, 0x8 and 0xC. Offsets 0x10 to 0x1C read zero and ignore writes. An access with `busAddr[1:0]` nonzero is ignored and reads zero. Control reads back only bits 15:8 and 2:0, so writing all ones reads back 0x0000FF07.
- R3: While running, the count changes on a "tick". A tick occurs once every P+1 clock cycles.
- R4: The tick that takes the count from 1 to 0 sets the event flag (bit 0 of 0xC). In one-shot mode the counter then halts and the count stays 0. A tick taken at count 0 in one-shot mode sets the flag and halts.
- R5: In auto-reload mode, the tick after reaching 0 reloads the count from the reload register. The period is therefore (reload+1) ticks. With reload 0 and P nonzero, the flag is set on every tick.
- R6: In auto-reload mode with P = 0 and reload = 0, expiry sets the flag once and the counter then halts.
- R7: A reload-register write also loads the count with the same value. If this write is zero while enabled with P = 0, the counter halts without setting the flag.
- R8: A count write of zero while enabled with P = 0 behaves in one of two ways. In one-shot mode, or when reload is 0, it halts the counter without an event. In auto-reload mode with a nonzero reload, the count takes the reload value instead.
- R9: A write starts the counter only if enable is set and either P is nonzero or the resulting count is nonzero.
- R10: A control write that changes bits 1:0 halts the counter. A control write that sets both enable and auto-reload while the count is 0 first copies the reload value into the count.
- R11: `irq` equals the event flag ANDed with control bit 2. Writing 1 to bit 0 of 0xC clears the flag. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R12: A write to the reload, count or control register suppresses any tick in that cycle. Any write that starts the counter from halt, and any reload or count write that leaves it running, restarts the divider. The next tick therefore comes P+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe for this timer's window |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address inside the 32-byte window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busSel is high and busWr is low |
| irq | output | 1 | Level interrupt: event flag AND interrupt enable |

## Verification
The properties assume three things about the inputs. Reset is asserted before the first clock. Each access is confined to a single clock cycle. Only the bus changes registers, so the count may move without a bus write only by a decrement or a reload. The bench drives the bus only on falling edges, with one access per cycle. It uses word-aligned offsets except in the single case where misaligned access is deliberately exercised. It holds reset for several cycles at the start. The bench's model follows every cycle, including back-to-back writes that collide with ticks and expiries.

// File: rtl/core_timer_pkg.sv
package core_timer_pkg;

  localparam int DATA_W  = 32;
  localparam int PRE_W   = 8;
  localparam int PRE_LSB = 8;
  localparam int ADDR_W  = 5;
  localparam int IDX_W   = ADDR_W - 2;

  localparam int BIT_EN  = 0;
  localparam int BIT_PER = 1;
  localparam int BIT_IE  = 2;

  localparam logic [IDX_W-1:0] IDX_LOAD  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_COUNT = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_FLAG  = IDX_W'(3);

  typedef struct packed {
    logic             per;
    logic [PRE_W-1:0] pre;
  } tmrCfg_t;

  typedef struct packed {
    logic              loadWe;
    logic              countWe;
    logic [DATA_W-1:0] value;
    logic              runSet;
    logic              runClr;
    logic              divRestart;
    logic              freeze;
  } dpStrobe_t;

endpackage

// File: rtl/core_timer_ctrl.sv
module core_timer_ctrl
  import core_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] countVal,
  input  logic              running,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output tmrCfg_t           cfg,
  output logic              flag,
  output logic              irq,
  output logic              ctrlEn
);

  localparam logic [DATA_W-1:0] ZERO_W = '0;

  logic             ctrlPer;
  logic             ctrlIe;
  logic [PRE_W-1:0] ctrlPre;

  logic             aligned;
  logic [IDX_W-1:0] regIdx;
  logic             wrHit;
  logic             rdHit;
  logic             preNz;
  logic             wrDataNz;

  // control-write decode
  logic [PRE_W-1:0]  newPre;
  logic              newEn;
  logic              newPer;
  logic              modeChg;
  logic              refillZero;
  logic [DATA_W-1:0] ctrlEffCount;
  logic              ctrlStart;

  // count-write decode
  logic              cntSubst;
  logic [DATA_W-1:0] cntEff;
  logic              cntStart;

  // load-write decode
  logic              ldStart;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign regIdx   = busAddr[ADDR_W-1:2];
  assign wrHit    = busSel && busWr && aligned;
  assign rdHit    = busSel && !busWr && aligned;
  assign preNz    = (ctrlPre != '0);
  assign wrDataNz = (busWdata != ZERO_W);

  assign ldStart = ctrlEn && (preNz || wrDataNz);

  assign cntSubst = ctrlEn && ctrlPer && !preNz && !wrDataNz;
  assign cntEff   = cntSubst ? loadVal : busWdata;
  assign cntStart = ctrlEn && (preNz || (cntEff != ZERO_W));

  assign newPre       = busWdata[PRE_LSB +: PRE_W];
  assign newEn        = busWdata[BIT_EN];
  assign newPer       = busWdata[BIT_PER];
  assign modeChg      = (newEn != ctrlEn) || (newPer != ctrlPer);
  assign refillZero   = newEn && newPer && (countVal == ZERO_W);
  assign ctrlEffCount = refillZero ? loadVal : countVal;
  assign ctrlStart    = newEn && ((newPre != '0) || (ctrlEffCount != ZERO_W));

  always_comb begin
    strobe       = '0;
    strobe.value = busWdata;
    if (wrHit) begin
      unique case (regIdx)
        IDX_LOAD: begin
          strobe.loadWe     = 1'b1;
          strobe.countWe    = 1'b1;
          strobe.freeze     = 1'b1;
          strobe.runSet     = ldStart;
          strobe.runClr     = !ldStart;
          strobe.divRestart = ldStart;
        end
        IDX_COUNT: begin
          strobe.countWe    = 1'b1;
          strobe.value      = cntEff;
          strobe.freeze     = 1'b1;
          strobe.runSet     = cntStart;
          strobe.runClr     = !cntStart;
          strobe.divRestart = cntStart;
        end
        IDX_CTRL: begin
          strobe.countWe    = refillZero;
          strobe.value      = loadVal;
          strobe.freeze     = 1'b1;
          strobe.runSet     = ctrlStart;
          strobe.runClr     = !ctrlStart;
          strobe.divRestart = ctrlStart && (!running || modeChg);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      ctrlPer <= 1'b0;
      ctrlIe  <= 1'b0;
      ctrlPre <= '0;
    end else if (wrHit && (regIdx == IDX_CTRL)) begin
      ctrlEn  <= newEn;
      ctrlPer <= newPer;
      ctrlIe  <= busWdata[BIT_IE];
      ctrlPre <= newPre;
    end
  end

  // expiry wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (expire) begin
      flag <= 1'b1;
    end else if (wrHit && (regIdx == IDX_FLAG) && busWdata[0]) begin
      flag <= 1'b0;
    end
  end

  assign cfg.per = ctrlPer;
  assign cfg.pre = ctrlPre;
  assign irq     = flag && ctrlIe;

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      unique case (regIdx)
        IDX_LOAD:  busRdata = loadVal;
        IDX_COUNT: busRdata = countVal;
        IDX_CTRL: begin
          busRdata[BIT_EN]              = ctrlEn;
          busRdata[BIT_PER]             = ctrlPer;
          busRdata[BIT_IE]              = ctrlIe;
          busRdata[PRE_LSB +: PRE_W]    = ctrlPre;
        end
        IDX_FLAG:  busRdata[0] = flag;
        default:   busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/core_timer_datapath.sv
module core_timer_datapath
  import core_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  tmrCfg_t           cfg,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] countVal,
  output logic              running,
  output logic              expire
);

  localparam logic [DATA_W-1:0] ONE_W  = DATA_W'(1);
  localparam logic [DATA_W-1:0] ZERO_W = '0;

  logic [PRE_W-1:0] divCnt;
  logic             tickNow;
  logic             atOne;
  logic             atZero;
  logic             loadZero;
  logic             preZero;
  logic             haltAtEnd;
  logic             stopNow;

  assign tickNow   = running && !strobe.freeze && (divCnt >= cfg.pre);
  assign atOne     = (countVal == ONE_W);
  assign atZero    = (countVal == ZERO_W);
  assign loadZero  = (loadVal == ZERO_W);
  assign preZero   = (cfg.pre == '0);
  assign haltAtEnd = !cfg.per || (preZero && loadZero);
  assign stopNow   = (atOne || atZero) && haltAtEnd;
  assign expire    = tickNow && (atOne || (atZero && (!cfg.per || loadZero)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal <= '0;
    end else if (strobe.loadWe) begin
      loadVal <= strobe.value;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobe.countWe) begin
      countVal <= strobe.value;
    end else if (tickNow) begin
      if (!atZero) begin
        countVal <= countVal - ONE_W;
      end else if (cfg.per) begin
        countVal <= loadVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (strobe.runClr) begin
      running <= 1'b0;
    end else if (strobe.runSet) begin
      running <= 1'b1;
    end else if (tickNow && stopNow) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.divRestart || tickNow) begin
      divCnt <= '0;
    end else if (running && !strobe.freeze) begin
      divCnt <= divCnt + PRE_W'(1);
    end
  end

endmodule

// File: rtl/core_private_timer.sv
module core_private_timer
  import core_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  dpStrobe_t         strobe;
  tmrCfg_t           cfg;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] countVal;
  logic              running;
  logic              expire;
  logic              flag;
  logic              ctrlEn;

  core_timer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .loadVal  (loadVal),
    .countVal (countVal),
    .running  (running),
    .expire   (expire),
    .strobe   (strobe),
    .cfg      (cfg),
    .flag     (flag),
    .irq      (irq),
    .ctrlEn   (ctrlEn)
  );

  core_timer_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfg      (cfg),
    .loadVal  (loadVal),
    .countVal (countVal),
    .running  (running),
    .expire   (expire)
  );

endmodule

// File: rtl/core_private_timer_checker.sv
module core_private_timer_checker
  import core_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              running,
  input logic              expire,
  input logic              flag,
  input logic              per,
  input logic              en,
  input logic [PRE_W-1:0]  pre,
  input logic [DATA_W-1:0] loadVal,
  input logic [DATA_W-1:0] countVal
);

  logic anyWr;
  logic zeroLoadWr;
  assign anyWr      = busSel && busWr;
  assign zeroLoadWr = anyWr && (busAddr == ADDR_W'(0)) && (busWdata == '0)
                      && en && (pre == '0);

  // R1: leaving reset, the counter is halted at zero
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!running && countVal == '0 && !flag));

  // R9: without a bus write a halted counter holds its value
  p_hold_halted_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !anyWr) |=> $stable(countVal));

  // R3: without a bus write the count only steps down by one or reloads
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && !anyWr) |=> (countVal == $past(countVal)
                             || countVal == $past(countVal) - DATA_W'(1)
                             || countVal == $past(loadVal)));

  // R4: one-shot expiry halts the counter
  p_oneshot_halts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !per) |=> !running);

  // R11: an expiry always leaves the flag set
  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> flag);

  // R7: zero reload with divider zero halts with no event
  p_zero_load_halt_r7: assert property (@(posedge clk) disable iff (!rstN)
    zeroLoadWr |=> (!running && countVal == '0));

endmodule

bind core_private_timer core_private_timer_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .running  (running),
  .expire   (expire),
  .flag     (flag),
  .per      (cfg.per),
  .en       (ctrlEn),
  .pre      (cfg.pre),
  .loadVal  (loadVal),
  .countVal (countVal)
);

// File: tb/core_private_timer_tb.sv
`timescale 1ns/1ps
module core_private_timer_tb;

  localparam real HALF = 4.0;
  localparam logic [4:0] A_LOAD = 5'h00;
  localparam logic [4:0] A_CNT  = 5'h04;
  localparam logic [4:0] A_CTL  = 5'h08;
  localparam logic [4:0] A_FLG  = 5'h0C;
  localparam logic [31:0] EN  = 32'h1;
  localparam logic [31:0] PER = 32'h2;
  localparam logic [31:0] IE  = 32'h4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] mLoad, mCount, mCtrl;
  bit          mFlag, mRun, mTouched, mChg;
  int          mDiv;
  logic [31:0] mV;

  always #(HALF) clk = ~clk;

  core_private_timer u_dut (
    .clk(clk), .rstN(rstN), .busSel(sel), .busWr(wr), .busAddr(addr),
    .busWdata(wdata), .busRdata(rdata), .irq(irq)
  );

  function automatic int mPre();
    return int'(mCtrl[15:8]);
  endfunction

  task automatic mStart(input logic [31:0] v, input bit restart);
    if (mCtrl[0] && (mPre() != 0 || v != 0)) begin
      if (restart) mDiv = 0;
      mRun = 1;
    end else begin
      mRun = 0;
    end
  endtask

  task automatic mTick();
    if (mCount > 1) begin
      mCount = mCount - 1;
    end else if (mCount == 1) begin
      mCount = 0;
      mFlag = 1;
      if (!mCtrl[1] || (mPre() == 0 && mLoad == 0)) mRun = 0;
    end else if (mCtrl[1]) begin
      mCount = mLoad;
      if (mLoad == 0) begin
        mFlag = 1;
        if (mPre() == 0) mRun = 0;
      end
    end else begin
      mFlag = 1;
      mRun = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mLoad = 0; mCount = 0; mCtrl = 0; mFlag = 0; mRun = 0; mDiv = 0;
    end else begin
      mTouched = 0;
      if (sel && wr && addr[1:0] == 2'b00) begin
        case (addr[4:2])
          3'd0: begin
            mLoad = wdata; mCount = wdata; mTouched = 1; mStart(wdata, 1);
          end
          3'd1: begin
            mV = wdata;
            if (mCtrl[1:0] == 2'b11 && mPre() == 0 && mV == 0) mV = mLoad;
            mCount = mV; mTouched = 1; mStart(mV, 1);
          end
          3'd2: begin
            mChg = (mCtrl[1:0] != wdata[1:0]);
            mCtrl = wdata & 32'h0000FF07;
            if (mCtrl[1:0] == 2'b11 && mCount == 0) mCount = mLoad;
            mTouched = 1;
            mStart(mCount, mChg || !mRun);
          end
          3'd3: if (wdata[0]) mFlag = 0;
          default: ;
        endcase
      end
      if (!mTouched && mRun) begin
        if (mDiv < mPre()) mDiv++;
        else begin mDiv = 0; mTick(); end
      end
    end
  end

  function automatic logic [31:0] mRead(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 0;
    case (a[4:2])
      3'd0: return mLoad;
      3'd1: return mCount;
      3'd2: return mCtrl;
      3'd3: return {31'b0, mFlag};
      default: return 0;
    endcase
  endfunction

  // R11: irq compared with the model on every cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      nChecks++;
      if (irq !== (mFlag && mCtrl[2])) begin
        nErrors++;
        $display("FAIL R11 irq at %0t: actual %0b expected %0b", $time, irq, mFlag && mCtrl[2]);
      end
    end
  end

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0; wdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdCheck(input logic [4:0] a, input logic [31:0] exp, input string tag);
    sel = 1; wr = 0; addr = a;
    #1;
    nChecks++;
    if (rdata !== exp) begin
      nErrors++;
      $display("FAIL %s read 0x%0h: actual 0x%0h expected 0x%0h", tag, a, rdata, exp);
    end
    @(negedge clk);
    sel = 0;
  endtask

  task automatic chkLit(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rdCheck(a, exp, tag);
  endtask

  task automatic chkMdl(input logic [4:0] a, input string tag);
    rdCheck(a, mRead(a), tag);
  endtask

  task automatic chkIrq(input bit exp, input string tag);
    nChecks++;
    if (irq !== exp) begin
      nErrors++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    nErrors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  logic [31:0] snapA;

  initial begin
    idle(4);
    rstN = 1;
    idle(1);
    // R1
    chkLit(A_LOAD, 0, "R1"); chkLit(A_CNT, 0, "R1");
    chkLit(A_CTL, 0, "R1");  chkLit(A_FLG, 0, "R1");
    chkIrq(0, "R1");

    // R2: control mask, reserved and misaligned offsets
    wrReg(A_CTL, 32'hFFFF_FFFF);
    chkLit(A_CTL, 32'h0000_FF07, "R2");
    wrReg(A_CTL, 0);
    wrReg(A_FLG, 1);
    wrReg(5'h10, 32'h1234_5678);
    wrReg(5'h1C, 32'hFFFF_FFFF);
    wrReg(5'h01, 32'd9);
    chkLit(5'h10, 0, "R2"); chkLit(5'h14, 0, "R2");
    chkLit(5'h1C, 0, "R2"); chkLit(5'h01, 0, "R2");
    chkLit(A_LOAD, 0, "R2"); chkLit(A_CTL, 0, "R2");

    // R7 load also sets count; R4 one-shot expiry
    wrReg(A_CTL, IE);
    wrReg(A_LOAD, 5);
    chkLit(A_CNT, 5, "R7");
    wrReg(A_CTL, IE | EN);
    idle(4);
    chkLit(A_FLG, 0, "R4");
    chkLit(A_FLG, 1, "R4");
    chkLit(A_CNT, 0, "R4");
    idle(5);
    chkLit(A_CNT, 0, "R4");
    chkIrq(1, "R11");
    wrReg(A_FLG, 0);
    chkIrq(1, "R11");
    wrReg(A_FLG, 1);
    chkIrq(0, "R11");

    // R3 / R5: auto-reload with divider 2
    wrReg(A_CTL, IE | EN | PER | (32'd2 << 8));
    for (int i = 0; i < 20; i++) begin
      idle(2);
      chkMdl(A_CNT, "R3");
      chkMdl(A_FLG, "R5");
    end

    // R7: zero reload with divider 0 halts quietly
    wrReg(A_CTL, IE | EN | PER);
    wrReg(A_FLG, 1);
    wrReg(A_LOAD, 0);
    idle(5);
    chkLit(A_CNT, 0, "R7");
    chkLit(A_FLG, 0, "R7");

    // R6: auto-reload, divider 0, reload 0 -> single event
    wrReg(A_CNT, 4);
    idle(8);
    chkLit(A_FLG, 1, "R6");
    wrReg(A_FLG, 1);
    idle(10);
    chkLit(A_FLG, 0, "R6");
    chkLit(A_CNT, 0, "R6");

    // R8: count write of zero
    wrReg(A_LOAD, 7);
    wrReg(A_CNT, 0);
    chkLit(A_CNT, 7, "R8");
    wrReg(A_CTL, IE | EN);
    wrReg(A_FLG, 1);
    wrReg(A_CNT, 0);
    idle(10);
    chkLit(A_CNT, 0, "R8");
    chkLit(A_FLG, 0, "R8");

    // R9: start condition
    wrReg(A_CTL, IE | EN);
    idle(5);
    chkLit(A_FLG, 0, "R9");
    wrReg(A_CTL, IE | EN | (32'd3 << 8));
    idle(3);
    chkLit(A_FLG, 0, "R9");
    chkLit(A_FLG, 1, "R9");

    // R10: refill on enable+auto-reload, halt on mode change
    wrReg(A_FLG, 1);
    wrReg(A_CTL, IE | EN | PER | (32'd1 << 8));
    chkLit(A_CNT, 7, "R10");
    idle(6);
    wrReg(A_CTL, IE | (32'd1 << 8));
    sel = 1; wr = 0; addr = A_CNT; #1; snapA = rdata; @(negedge clk); sel = 0;
    idle(6);
    chkLit(A_CNT, snapA, "R10");
    chkMdl(A_CNT, "R10");

    // R12: writes win over ticks
    wrReg(A_CTL, IE | EN);
    for (int i = 0; i < 5; i++) wrReg(A_CNT, 32'd20 + i);
    chkLit(A_CNT, 24, "R12");

    // R11: expiry and clear in the same cycle
    wrReg(A_FLG, 1);
    wrReg(A_LOAD, 3);
    idle(2);
    wrReg(A_FLG, 1);
    chkLit(A_FLG, 1, "R11");
    wrReg(A_CTL, EN);
    chkIrq(0, "R11");
    chkLit(A_FLG, 1, "R11");

    // R12: divider restart on reload write
    wrReg(A_CTL, IE | EN | PER | (32'd3 << 8));
    idle(2);
    wrReg(A_LOAD, 10);
    idle(3);
    chkLit(A_CNT, 10, "R12");
    chkLit(A_CNT, 9, "R12");

    for (int i = 0; i < 10; i++) begin
      idle(3);
      chkMdl(A_CNT, "R5");
    end

    summary();
    $finish;
  end

endmodule